// File: doc/BRIEF.md
# Dual-Direction Gated-Latch Bus Transceiver

This block couples two 8-bit ports, A and B, through two independent banks of level-sensitive storage latches. One bank captures data arriving on A and presents it toward B. The other captures data arriving on B and presents it toward A. Data is never inverted, and bit i of one port always maps to bit i of the other.

Each direction has three active-low controls: a chip select, a capture gate and a drive enable. The chip select qualifies both loading and driving. While chip select and capture gate are both low, the bank is transparent and follows its source. When the capture gate rises, the bank holds its contents. The far port drives the stored value only while chip select and drive enable are both low.

Each tri-state pin group is split into three signals: an input vector, an output vector and a single drive flag. The surrounding pad logic recombines them. An active-high reset clears both banks while it is held. The clock input serves only as the sampling point for the embedded property checks.

Top module: `dual_latch_xcvr`

## Requirements
- R1: While a direction's chip select and capture gate are both low (and reset is low), that direction's bank follows its source port bit for bit with no inversion, and the far port shows the new value without waiting for a clock.
- R2: After the capture gate of a direction goes high, its bank keeps the value present just before the rising level, whatever the source port does afterwards.
- R3: While a direction's chip select is high, its bank does not load, even when its capture gate is low.
- R4: A port's drive flag is 1 exactly when the opposite direction's chip select and drive enable are both low. While the flag is 1, the port's output vector equals that direction's stored bank value.
- R5: While a port's drive flag is 0, its output vector reads all zeros.
- R6: A bank loads through its capture gate even while its drive enable is high, and the loaded value appears once driving is enabled.
- R7: The two directions are independent. Loading or holding one bank never alters the other, and both ports may drive at the same time.
- R8: While reset is high, both banks are cleared to zero, and reset takes priority over an open capture gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the embedded property checks only |
| rst | input | 1 | Active-high clear of both banks |
| a_in | input | 8 | Value sensed on port A (source of the A-to-B bank) |
| a_out | output | 8 | Value driven onto port A from the B-to-A bank |
| a_oe | output | 1 | High when port A is being driven |
| b_in | input | 8 | Value sensed on port B (source of the B-to-A bank) |
| b_out | output | 8 | Value driven onto port B from the A-to-B bank |
| b_oe | output | 1 | High when port B is being driven |
| ab_cs_n | input | 1 | A-to-B chip select, active low |
| ab_cap_n | input | 1 | A-to-B capture gate, active low (low = transparent) |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ba_cs_n | input | 1 | B-to-A chip select, active low |
| ba_cap_n | input | 1 | B-to-A capture gate, active low (low = transparent) |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |

## Verification
A bank that captures at the wrong time or fails to hold shows up on the far port as soon as that port is driven. The value shown is then the later source word instead of the one present when the capture gate rose. Because the path is purely level-sensitive, the wrong value appears in the same cycle the controls allow driving. A bank that fails to load while its output is disabled stays hidden until the drive enable falls, so the bench re-enables driving right after such loads. Any crosstalk between the two banks shows up the moment the other direction drives again after a one-sided load.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_DATA_W = 8;
    localparam int unsigned XCVR_DIRS   = 2;

    // direction index: 0 carries A toward B, 1 carries B toward A
    typedef enum logic {
        DIR_A2B = 1'b0,
        DIR_B2A = 1'b1
    } xcvr_dir_e;

    // per-direction active-low control group
    typedef struct packed {
        logic cs_n;
        logic cap_n;
        logic drv_n;
    } xcvr_ctrl_t;

    function automatic logic xcvr_gate_open(input xcvr_ctrl_t c);
        return (~c.cs_n) & (~c.cap_n);
    endfunction

    function automatic logic xcvr_drive_on(input xcvr_ctrl_t c);
        return (~c.cs_n) & (~c.drv_n);
    endfunction

endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  xcvr_ctrl_t       ctrl,
    input  logic [W-1:0]     d,
    output logic [W-1:0]     q
);

    logic gate;

    assign gate = xcvr_gate_open(ctrl);

    always_latch begin
        if (rst) begin
            q <= '0;
        end else if (gate) begin
            q <= d;
        end
    end

    assert_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.cs_n && !ctrl.cap_n) |-> (q == d));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ctrl.cap_n && $past(ctrl.cap_n)) |-> $stable(q));

    assert_no_load_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ctrl.cs_n && $past(ctrl.cs_n)) |-> $stable(q));

    assert_clear_R8: assert property (@(posedge clk)
        rst |-> (q == '0));

endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_DATA_W
) (
    input  xcvr_ctrl_t       ctrl,
    input  logic [W-1:0]     stored,
    output logic [W-1:0]     pin_out,
    output logic             pin_oe
);

    always_comb begin
        pin_oe  = xcvr_drive_on(ctrl);
        pin_out = pin_oe ? stored : '0;
    end

endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = XCVR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe,
    input  logic              ab_cs_n,
    input  logic              ab_cap_n,
    input  logic              ab_drv_n,
    input  logic              ba_cs_n,
    input  logic              ba_cap_n,
    input  logic              ba_drv_n
);

    localparam int unsigned NDIR = XCVR_DIRS;

    xcvr_ctrl_t        ctl   [NDIR];
    logic [DATA_W-1:0] src   [NDIR];
    logic [DATA_W-1:0] store [NDIR];
    logic [DATA_W-1:0] dout  [NDIR];
    logic              doe   [NDIR];

    assign ctl[DIR_A2B] = '{cs_n: ab_cs_n, cap_n: ab_cap_n, drv_n: ab_drv_n};
    assign ctl[DIR_B2A] = '{cs_n: ba_cs_n, cap_n: ba_cap_n, drv_n: ba_drv_n};
    assign src[DIR_A2B] = a_in;
    assign src[DIR_B2A] = b_in;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        xcvr_latch_bank #(.W(DATA_W)) bank_i (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctl[g]),
            .d    (src[g]),
            .q    (store[g])
        );

        xcvr_port_drive #(.W(DATA_W)) drive_i (
            .ctrl    (ctl[g]),
            .stored  (store[g]),
            .pin_out (dout[g]),
            .pin_oe  (doe[g])
        );
    end

    assign b_out = dout[DIR_A2B];
    assign b_oe  = doe[DIR_A2B];
    assign a_out = dout[DIR_B2A];
    assign a_oe  = doe[DIR_B2A];

    assert_b_drive_R4: assert property (@(posedge clk) disable iff (rst)
        b_oe |-> (!ab_cs_n && !ab_drv_n && b_out == store[DIR_A2B]));

    assert_a_drive_R4: assert property (@(posedge clk) disable iff (rst)
        a_oe |-> (!ba_cs_n && !ba_drv_n && a_out == store[DIR_B2A]));

    assert_b_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !b_oe |-> (b_out == '0));

    assert_a_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !a_oe |-> (a_out == '0));

    assert_split_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ba_cs_n && $past(ba_cs_n) && !ab_cs_n && !ab_cap_n)
        |-> $stable(store[DIR_B2A]));

endmodule

// File: tb/dual_latch_xcvr_tb_top.sv
module dual_latch_xcvr_tb_top;

    localparam int unsigned W      = 8;
    localparam time         HALF   = 2ns;
    localparam int unsigned NVEC   = 12;
    localparam int unsigned WD_CYC = 200000;

    typedef struct packed {
        logic         cs_n;
        logic         cap_n;
        logic         drv_n;
        logic [W-1:0] din;
        logic         exp_oe;
        logic [W-1:0] exp_out;
    } vec_t;

    // one direction's sequence, starting from a cleared bank
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 8'hA5},  // R1 transparent
        '{1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 8'h3C},  // R1 follows change
        '{1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 8'h3C},  // R2 stored on rise
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h3C},  // R2 holds
        '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00},  // R5 drive off
        '{1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 8'h00},  // R3/R4 cs high
        '{1'b0, 1'b1, 1'b0, 8'h77, 1'b1, 8'h3C},  // R3 nothing loaded
        '{1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 8'h00},  // R6 load hidden
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h81},  // R6 shows load
        '{1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},  // R4 cs high
        '{1'b0, 1'b0, 1'b0, 8'h5A, 1'b1, 8'h5A},  // R1
        '{1'b0, 1'b1, 1'b0, 8'h12, 1'b1, 8'h5A}   // R2
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_cs_n, ab_cap_n, ab_drv_n;
    logic         ba_cs_n, ba_cap_n, ba_drv_n;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #HALF clk = ~clk;

    dual_latch_xcvr #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_cs_n(ab_cs_n), .ab_cap_n(ab_cap_n), .ab_drv_n(ab_drv_n),
        .ba_cs_n(ba_cs_n), .ba_cap_n(ba_cap_n), .ba_drv_n(ba_drv_n)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ab(input logic cs, input logic cap, input logic drv);
        ab_cs_n = cs; ab_cap_n = cap; ab_drv_n = drv;
    endtask

    task automatic set_ba(input logic cs, input logic cap, input logic drv);
        ba_cs_n = cs; ba_cap_n = cap; ba_drv_n = drv;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0;
        set_ab(1, 1, 1); set_ba(1, 1, 1);
        repeat (3) @(negedge clk);
        #1;
        check("R8 reset b_oe", {7'b0, b_oe}, 8'h00);
        check("R8 reset a_oe", {7'b0, a_oe}, 8'h00);
        settle(); rst = 1'b0;
        set_ab(0, 1, 0); set_ba(0, 1, 0);
        #1;
        check("R8 cleared A2B bank", b_out, 8'h00);
        check("R8 cleared B2A bank", a_out, 8'h00);
        settle(); set_ab(1, 1, 1); set_ba(1, 1, 1);

        // table, A toward B
        for (int i = 0; i < NVEC; i++) begin
            settle();
            set_ab(VECS[i].cs_n, VECS[i].cap_n, VECS[i].drv_n);
            a_in = VECS[i].din;
            #1;
            check($sformatf("R4 A2B flag v%0d", i), {7'b0, b_oe}, {7'b0, VECS[i].exp_oe});
            check($sformatf("R1/R2/R3/R5/R6 A2B data v%0d", i), b_out, VECS[i].exp_out);
            check($sformatf("R7 A idle v%0d", i), {7'b0, a_oe}, 8'h00);
        end
        settle(); set_ab(1, 1, 1);

        // table, B toward A (bank still cleared from reset)
        for (int i = 0; i < NVEC; i++) begin
            settle();
            set_ba(VECS[i].cs_n, VECS[i].cap_n, VECS[i].drv_n);
            b_in = VECS[i].din;
            #1;
            check($sformatf("R4 B2A flag v%0d", i), {7'b0, a_oe}, {7'b0, VECS[i].exp_oe});
            check($sformatf("R1/R2/R3/R5/R6 B2A data v%0d", i), a_out, VECS[i].exp_out);
            check($sformatf("R7 B idle v%0d", i), {7'b0, b_oe}, 8'h00);
        end

        // R7: both directions loaded and driving together
        settle();
        set_ab(0, 0, 0); set_ba(0, 0, 0); a_in = 8'h11; b_in = 8'h22;
        #1;
        check("R7 both drive b_oe", {7'b0, b_oe}, 8'h01);
        check("R7 both drive a_oe", {7'b0, a_oe}, 8'h01);
        check("R7 b_out", b_out, 8'h11);
        check("R7 a_out", a_out, 8'h22);
        settle();
        set_ab(0, 1, 0); set_ba(0, 1, 0);
        settle();
        a_in = 8'hEE; b_in = 8'hDD;
        #1;
        check("R2 b holds", b_out, 8'h11);
        check("R2 a holds", a_out, 8'h22);
        settle();
        set_ab(1, 1, 1); set_ba(0, 0, 0); b_in = 8'h33;
        #1;
        check("R7 only B2A loads", a_out, 8'h33);
        settle();
        set_ba(0, 1, 0);
        settle();
        set_ab(0, 1, 0);
        #1;
        check("R7 A2B bank untouched", b_out, 8'h11);
        check("R7 B2A kept", a_out, 8'h33);

        // R8: reset clears a loaded bank and overrides an open gate
        settle();
        set_ab(0, 0, 0); a_in = 8'h99;
        #1;
        check("R1 before reset", b_out, 8'h99);
        settle(); rst = 1'b1;
        #1;
        check("R8 clear overrides gate", b_out, 8'h00);
        check("R8 clear B2A", a_out, 8'h00);
        settle(); set_ab(0, 1, 0);
        settle(); rst = 1'b0;
        #1;
        check("R8 stays clear after release", b_out, 8'h00);

        settle();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule